// File: doc/BRIEF.md
# Progressive Output Video Timing Generator

This block produces the progressive-scan output timing for a video path running on a single pixel clock. A horizontal pixel counter restarts on every leading edge of the incoming horizontal sync, and a line counter restarts on every leading edge of the incoming vertical sync. Both counters are compared against a set of programmable windows to form the output horizontal and vertical syncs, a per-line reference strobe, a blanking flag, a border flag and a visible-picture flag.

Every window edge is an 8-bit value held outside the block. Horizontal values count in steps of 8 pixels and vertical values in steps of 4 lines. The line length is assembled from an 8-bit high part and a 2-bit low part, and its least significant bit is always zero. Any window whose start lies beyond its end wraps across the end of the line or frame. When software timing is off, a built-in 780-pixel timing set is used in place of the register inputs. The block also measures the number of input lines between consecutive vertical sync leading edges.

Top module: `vid_tgen`

## Requirements
- R1: The pixel counter becomes 0 on the clock edge that samples an input horizontal sync leading edge. Otherwise it wraps to 0 after the value total−1, where total = {htot_hi[7:0], htot_lo[1:0], 1'b0} (htot_hi=61h, htot_lo=2 gives 780). A line longer than the total therefore restarts the count without any sync edge.
- R2: A horizontal window given by register values s and e covers the pixels p with 8·s ≤ p < 8·e when s < e. When s > e it covers p ≥ 8·s together with p < 8·e, wrapping past the line end. When s = e it is empty.
- R3: The line counter becomes 0 on an input vertical sync leading edge and otherwise increments on each input horizontal sync leading edge. Vertical windows follow the rules of R2 with a scale of 4 lines.
- R4: ghs is asserted while the pixel is inside the sync window and gvs while the line is inside the vertical sync window. An output polarity bit of 1 makes the output active high, and 0 makes it active low.
- R5: With an input polarity bit of 1, the leading edge of the input sync is its rising edge. With a polarity bit of 0, the leading edge is its falling edge.
- R6: ghref is high exactly when the pixel lies outside the horizontal blank window.
- R7: blank is high when the pixel is inside the horizontal blank window or the line is inside the vertical blank window.
- R8: visible is the AND of the horizontal and vertical capture windows. border is high when the position is neither blanked nor visible.
- R9: With sw_timing = 0, all register inputs are ignored and these built-in values apply: total 780, capture 120–736, sync 776–56, blank 760–96, vertical capture 48–500, vertical sync 4–8 and vertical blank 508–40.
- R10: On each input vertical sync leading edge, det_vtotal loads the number of lines counted since the previous one.
- R11: During reset, ghs and gvs sit at their inactive levels, blank is 1, ghref, border and visible are 0, and det_vtotal is 0.
- R12: Each flag output shows the position the counters held one clock earlier. The pixel at count p therefore appears after the second rising edge that follows the sync leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_hs_pol | input | 1 | Input horizontal sync polarity, 1 = active high |
| in_vs_pol | input | 1 | Input vertical sync polarity, 1 = active high |
| out_hs_pol | input | 1 | Output horizontal sync polarity, 1 = active high |
| out_vs_pol | input | 1 | Output vertical sync polarity, 1 = active high |
| sw_timing | input | 1 | 1 = use register inputs, 0 = built-in timing |
| htot_hi | input | 8 | Line length bits 10:3 |
| htot_lo | input | 2 | Line length bits 2:1 |
| hcap_beg | input | 8 | Horizontal capture start, ×8 pixels |
| hcap_end | input | 8 | Horizontal capture end, ×8 pixels |
| hsync_beg | input | 8 | Output horizontal sync start, ×8 pixels |
| hsync_end | input | 8 | Output horizontal sync end, ×8 pixels |
| hblank_beg | input | 8 | Horizontal blank start, ×8 pixels |
| hblank_end | input | 8 | Horizontal blank end, ×8 pixels |
| vcap_beg | input | 8 | Vertical capture start, ×4 lines |
| vcap_end | input | 8 | Vertical capture end, ×4 lines |
| vsync_beg | input | 8 | Output vertical sync start, ×4 lines |
| vsync_end | input | 8 | Output vertical sync end, ×4 lines |
| vblank_beg | input | 8 | Vertical blank start, ×4 lines |
| vblank_end | input | 8 | Vertical blank end, ×4 lines |
| ghs | output | 1 | Output horizontal sync |
| gvs | output | 1 | Output vertical sync |
| ghref | output | 1 | Horizontal reference, high outside horizontal blank |
| blank | output | 1 | Blanking flag |
| border | output | 1 | Border-region flag |
| visible | output | 1 | Visible-picture flag |
| det_vtotal | output | 11 | Measured lines per input frame |

## Verification
Two situations are hardest to reach from the ports. The first is a pixel counter that wraps on its own total rather than on a sync edge. The bench produces it by driving lines 130 clocks long against a 100-pixel total, so the count passes through zero in the middle of the line. The second is a sync window that runs across the line end. A programmed set with the horizontal sync running from 88 to 8 exercises that case, and another set with equal start and end checks the empty window. Built-in timing is checked by filling every register input with an unrelated value and running 60 full 780-pixel lines, which is enough to reach the vertical capture start at line 48.

// File: rtl/vid_tgen.sv
module vid_tgen #(
  parameter int REG_W       = 8,
  parameter int H_SHIFT     = 3,
  parameter int V_SHIFT     = 2,
  parameter int VCNT_W      = 11,
  parameter int DEF_HTOT_HI = 97,
  parameter int DEF_HTOT_LO = 2,
  parameter int DEF_HCAP_B  = 15,
  parameter int DEF_HCAP_E  = 92,
  parameter int DEF_HS_B    = 97,
  parameter int DEF_HS_E    = 7,
  parameter int DEF_HBL_B   = 95,
  parameter int DEF_HBL_E   = 12,
  parameter int DEF_VCAP_B  = 12,
  parameter int DEF_VCAP_E  = 125,
  parameter int DEF_VS_B    = 1,
  parameter int DEF_VS_E    = 2,
  parameter int DEF_VBL_B   = 127,
  parameter int DEF_VBL_E   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_hs_pol,
  input  logic              in_vs_pol,
  input  logic              out_hs_pol,
  input  logic              out_vs_pol,
  input  logic              sw_timing,
  input  logic [REG_W-1:0]  htot_hi,
  input  logic [1:0]        htot_lo,
  input  logic [REG_W-1:0]  hcap_beg,
  input  logic [REG_W-1:0]  hcap_end,
  input  logic [REG_W-1:0]  hsync_beg,
  input  logic [REG_W-1:0]  hsync_end,
  input  logic [REG_W-1:0]  hblank_beg,
  input  logic [REG_W-1:0]  hblank_end,
  input  logic [REG_W-1:0]  vcap_beg,
  input  logic [REG_W-1:0]  vcap_end,
  input  logic [REG_W-1:0]  vsync_beg,
  input  logic [REG_W-1:0]  vsync_end,
  input  logic [REG_W-1:0]  vblank_beg,
  input  logic [REG_W-1:0]  vblank_end,
  output logic              ghs,
  output logic              gvs,
  output logic              ghref,
  output logic              blank,
  output logic              border,
  output logic              visible,
  output logic [VCNT_W-1:0] det_vtotal
);

  localparam int HCNT_W = REG_W + H_SHIFT;
  localparam int VPOS_W = REG_W + V_SHIFT;
  localparam int CW     = (HCNT_W > VCNT_W) ? HCNT_W : VCNT_W;

  function automatic logic in_win(input logic [CW-1:0] c, input logic [CW-1:0] s,
                                  input logic [CW-1:0] e);
    if (s <= e) return (c >= s) && (c < e);
    return (c >= s) || (c < e);
  endfunction

  function automatic logic [CW-1:0] hscale(input logic [REG_W-1:0] r);
    return CW'({r, {H_SHIFT{1'b0}}});
  endfunction

  function automatic logic [CW-1:0] vscale(input logic [REG_W-1:0] r);
    return CW'(VPOS_W'({r, {V_SHIFT{1'b0}}}));
  endfunction

  logic hs_act, vs_act, hs_q, vs_q, hs_lead, vs_lead;
  logic [HCNT_W-1:0] hcnt, htot_m1;
  logic [VCNT_W-1:0] vcnt;

  assign hs_act  = in_hs_pol ? in_hs : ~in_hs;
  assign vs_act  = in_vs_pol ? in_vs : ~in_vs;
  assign hs_lead = hs_act & ~hs_q;
  assign vs_lead = vs_act & ~vs_q;

  logic [REG_W-1:0] e_thi, e_hcb, e_hce, e_hsb, e_hse, e_hbb, e_hbe;
  logic [REG_W-1:0] e_vcb, e_vce, e_vsb, e_vse, e_vbb, e_vbe;
  logic [1:0]       e_tlo;

  assign e_thi = sw_timing ? htot_hi    : REG_W'(DEF_HTOT_HI);
  assign e_tlo = sw_timing ? htot_lo    : 2'(DEF_HTOT_LO);
  assign e_hcb = sw_timing ? hcap_beg   : REG_W'(DEF_HCAP_B);
  assign e_hce = sw_timing ? hcap_end   : REG_W'(DEF_HCAP_E);
  assign e_hsb = sw_timing ? hsync_beg  : REG_W'(DEF_HS_B);
  assign e_hse = sw_timing ? hsync_end  : REG_W'(DEF_HS_E);
  assign e_hbb = sw_timing ? hblank_beg : REG_W'(DEF_HBL_B);
  assign e_hbe = sw_timing ? hblank_end : REG_W'(DEF_HBL_E);
  assign e_vcb = sw_timing ? vcap_beg   : REG_W'(DEF_VCAP_B);
  assign e_vce = sw_timing ? vcap_end   : REG_W'(DEF_VCAP_E);
  assign e_vsb = sw_timing ? vsync_beg  : REG_W'(DEF_VS_B);
  assign e_vse = sw_timing ? vsync_end  : REG_W'(DEF_VS_E);
  assign e_vbb = sw_timing ? vblank_beg : REG_W'(DEF_VBL_B);
  assign e_vbe = sw_timing ? vblank_end : REG_W'(DEF_VBL_E);

  assign htot_m1 = HCNT_W'({e_thi, e_tlo, 1'b0}) - HCNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q       <= 1'b0;
      vs_q       <= 1'b0;
      hcnt       <= '0;
      vcnt       <= '0;
      det_vtotal <= '0;
    end else begin
      hs_q <= hs_act;
      vs_q <= vs_act;
      if (hs_lead || hcnt == htot_m1) hcnt <= '0;
      else                            hcnt <= hcnt + HCNT_W'(1);
      if (vs_lead) begin
        vcnt       <= '0;
        det_vtotal <= vcnt + VCNT_W'(1);
      end else if (hs_lead) begin
        vcnt <= vcnt + VCNT_W'(1);
      end
    end
  end

  logic [CW-1:0] hc, vc;
  logic w_hcap, w_hs, w_hbl, w_vcap, w_vs, w_vbl;

  assign hc     = CW'(hcnt);
  assign vc     = CW'(vcnt);
  assign w_hcap = in_win(hc, hscale(e_hcb), hscale(e_hce));
  assign w_hs   = in_win(hc, hscale(e_hsb), hscale(e_hse));
  assign w_hbl  = in_win(hc, hscale(e_hbb), hscale(e_hbe));
  assign w_vcap = in_win(vc, vscale(e_vcb), vscale(e_vce));
  assign w_vs   = in_win(vc, vscale(e_vsb), vscale(e_vse));
  assign w_vbl  = in_win(vc, vscale(e_vbb), vscale(e_vbe));

  logic hs_r, vs_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_r    <= 1'b0;
      vs_r    <= 1'b0;
      ghref   <= 1'b0;
      blank   <= 1'b1;
      border  <= 1'b0;
      visible <= 1'b0;
    end else begin
      hs_r    <= w_hs;
      vs_r    <= w_vs;
      ghref   <= ~w_hbl;
      blank   <= w_hbl | w_vbl;
      visible <= w_hcap & w_vcap;
      border  <= ~(w_hbl | w_vbl) & ~(w_hcap & w_vcap);
    end
  end

  assign ghs = out_hs_pol ? hs_r : ~hs_r;
  assign gvs = out_vs_pol ? vs_r : ~vs_r;

endmodule

// File: rtl/vid_tgen_chk.sv
module vid_tgen_chk #(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_lead,
  input logic              vs_lead,
  input logic [HCNT_W-1:0] hcnt,
  input logic [HCNT_W-1:0] htot_m1,
  input logic [VCNT_W-1:0] vcnt,
  input logic [VCNT_W-1:0] det_vtotal,
  input logic              blank,
  input logic              border,
  input logic              visible
);

  a_r1_hs_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lead |=> hcnt == '0);

  a_r1_total_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_lead && hcnt == htot_m1) |=> hcnt == '0);

  a_r3_vs_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead |=> vcnt == '0);

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_lead && !vs_lead) |=> vcnt == $past(vcnt) + VCNT_W'(1));

  a_r10_vtotal_load: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead |=> det_vtotal == $past(vcnt) + VCNT_W'(1));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({blank, border, visible}) == 1);

endmodule

bind vid_tgen vid_tgen_chk #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
  .hcnt(hcnt), .htot_m1(htot_m1), .vcnt(vcnt), .det_vtotal(det_vtotal),
  .blank(blank), .border(border), .visible(visible));

// File: tb/vid_tgen_tb_top.sv
module vid_tgen_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_hs, in_vs, ihp, ivp, ohp, ovp, sw;
  logic [7:0] thi, hcb, hce, hsb, hse, hbb, hbe, vcb, vce, vsb, vse, vbb, vbe;
  logic [1:0] tlo;
  logic ghs, gvs, ghref, blank, border, visible;
  logic [10:0] det_vtotal;

  vid_tgen dut_i (
    .clk(clk), .rst_n(rst_n), .in_hs(in_hs), .in_vs(in_vs),
    .in_hs_pol(ihp), .in_vs_pol(ivp), .out_hs_pol(ohp), .out_vs_pol(ovp),
    .sw_timing(sw), .htot_hi(thi), .htot_lo(tlo),
    .hcap_beg(hcb), .hcap_end(hce), .hsync_beg(hsb), .hsync_end(hse),
    .hblank_beg(hbb), .hblank_end(hbe), .vcap_beg(vcb), .vcap_end(vce),
    .vsync_beg(vsb), .vsync_end(vse), .vblank_beg(vbb), .vblank_end(vbe),
    .ghs(ghs), .gvs(gvs), .ghref(ghref), .blank(blank), .border(border),
    .visible(visible), .det_vtotal(det_vtotal));

  typedef struct {
    bit valid;
    bit hs, vs, href, blk, brd, vis;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "";

  function automatic bit win(int c, int s, int e);
    if (s < e) return (c >= s) && (c < e);
    if (s > e) return (c >= s) || (c < e);
    return 1'b0;
  endfunction

  function automatic item_t model(int h, int v);
    item_t r;
    int ht, a_hcb, a_hce, a_hsb, a_hse, a_hbb, a_hbe;
    int a_vcb, a_vce, a_vsb, a_vse, a_vbb, a_vbe, hp;
    bit s_h, s_v, hb, vb;
    if (sw) begin
      ht = thi * 8 + tlo * 2;
      a_hcb = hcb * 8; a_hce = hce * 8; a_hsb = hsb * 8; a_hse = hse * 8;
      a_hbb = hbb * 8; a_hbe = hbe * 8;
      a_vcb = vcb * 4; a_vce = vce * 4; a_vsb = vsb * 4; a_vse = vse * 4;
      a_vbb = vbb * 4; a_vbe = vbe * 4;
    end else begin
      // R9 built-in timing
      ht = 780;
      a_hcb = 120; a_hce = 736; a_hsb = 776; a_hse = 56; a_hbb = 760; a_hbe = 96;
      a_vcb = 48;  a_vce = 500; a_vsb = 4;   a_vse = 8;  a_vbb = 508; a_vbe = 40;
    end
    hp    = h % ht;
    s_h   = win(hp, a_hsb, a_hse);
    s_v   = win(v, a_vsb, a_vse);
    hb    = win(hp, a_hbb, a_hbe);
    vb    = win(v, a_vbb, a_vbe);
    r.valid = 1'b1;
    r.hs   = ohp ? s_h : !s_h;
    r.vs   = ovp ? s_v : !s_v;
    r.href = !hb;
    r.blk  = hb | vb;
    r.vis  = win(hp, a_hcb, a_hce) && win(v, a_vcb, a_vce);
    r.brd  = !(hb | vb) && !r.vis;
    return r;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_n(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() >= 2) begin
      item_t it;
      it = q.pop_front();
      if (it.valid) begin
        chk(ghs, it.hs, "R4 ghs");
        chk(gvs, it.vs, "R4 gvs");
        chk(ghref, it.href, "R6 ghref");
        chk(blank, it.blk, "R7 blank");
        chk(border, it.brd, "R8 border");
        chk(visible, it.vis, "R8 visible");
      end
    end
  end

  task automatic drive(input bit hs_a, input bit vs_a);
    in_hs = ihp ? hs_a : !hs_a;
    in_vs = ivp ? vs_a : !vs_a;
  endtask

  task automatic idle(input int n);
    item_t z;
    z = '{default: 0};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(1'b0, 1'b0);
      q.push_back(z);
    end
  endtask

  task automatic run(input int lines, input int len);
    for (int v = 0; v < lines; v++) begin
      for (int h = 0; h < len; h++) begin
        @(negedge clk);
        drive(h < 6, v < 3);
        q.push_back(model(h, v));
      end
    end
  endtask

  task automatic vs_probe(input int exp_lines);
    item_t z;
    z = '{default: 0};
    @(negedge clk);
    drive(1'b1, 1'b1);
    q.push_back(z);
    @(negedge clk);
    drive(1'b0, 1'b0);
    q.push_back(z);
    chk_n(det_vtotal, exp_lines, {"R10 det_vtotal ", tag});
    idle(4);
  endtask

  task automatic cfg_a();
    thi = 8'd12; tlo = 2'd2;
    hcb = 8'd2;  hce = 8'd10;
    hsb = 8'd11; hse = 8'd1;
    hbb = 8'd11; hbe = 8'd1;
    vcb = 8'd2;  vce = 8'd8;
    vsb = 8'd0;  vse = 8'd1;
    vbb = 8'd9;  vbe = 8'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ihp = 1; ivp = 1; ohp = 1; ovp = 1; sw = 1;
    cfg_a();
    in_hs = 0; in_vs = 0;
    repeat (4) @(negedge clk);
    tag = "R11";
    chk(ghs, 1'b0, "R11 ghs reset");
    chk(gvs, 1'b0, "R11 gvs reset");
    chk(ghref, 1'b0, "R11 ghref reset");
    chk(blank, 1'b1, "R11 blank reset");
    chk(border, 1'b0, "R11 border reset");
    chk(visible, 1'b0, "R11 visible reset");
    chk_n(det_vtotal, 0, "R11 det_vtotal reset");
    rst_n = 1;

    // R1 R2 R3 R12: wrapping sync window, positive polarities
    tag = "R1 R2 R3 R12 cfgA";
    idle(4);
    run(40, 100);
    vs_probe(40);

    // R5 and R4: all polarities inverted
    tag = "R5 R4 inverted";
    ihp = 0; ivp = 0; ohp = 0; ovp = 0;
    idle(4);
    run(40, 100);
    vs_probe(40);

    // R1: lines longer than the total wrap on the total
    tag = "R1 long line";
    ihp = 1; ivp = 1; ohp = 1; ovp = 1;
    idle(4);
    run(12, 130);
    vs_probe(12);

    // R2: empty sync window, non-wrapping blank
    tag = "R2 empty window";
    hsb = 8'd3; hse = 8'd3; hbb = 8'd0; hbe = 8'd1; vsb = 8'd2; vse = 8'd2;
    idle(4);
    run(12, 100);
    vs_probe(12);

    // R9: built-in timing, register inputs hold unrelated values
    tag = "R9 built-in";
    sw = 0;
    {thi, hcb, hce, hsb, hse, hbb, hbe} = {7{8'h33}};
    {vcb, vce, vsb, vse, vbb, vbe} = {6{8'h21}};
    tlo = 2'd1;
    idle(4);
    run(60, 780);
    vs_probe(60);

    idle(3);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule